// File: doc/BRIEF.md
# Interrupt Redirection Controller

This block routes interrupt requests from up to 24 input pins to processors as messages. Each pin owns a 64-bit redirection entry. The entry holds the vector, the delivery mode, the destination mode, the polarity, the trigger mode, a mask bit and an 8-bit destination. An unmasked raise on a pin produces one message, built from that pin's entry and from the controller's own identification value.

Software reaches the internal registers through a small 32-bit register port. It writes a register number to an index register at byte offset 0x00. It then reads or writes a data window at byte offset 0x10, and that access acts on the register the index selects. Behind the window are three registers and the redirection table:
- an identification register,
- a read-only version register,
- an arbitration register,
- the redirection table, with two indices per entry.

Pin events arrive as a pin number with a raise/lower flag. Messages leave through a valid/ready output. While the output is stalled, raises are held as one pending bit per pin. When the output frees up, they drain in ascending pin order.

Top module: `irq_router`

## Requirements
- R1: When reset is released, these reset values hold:
  - the index register is 0 and the arbitration register is 0;
  - the identification register equals the parameter `ID_RESET`;
  - entry 0 reads low word 0x00000700 (unmasked, delivery mode 3'b111 external interrupt) and high word 0;
  - every other entry reads low word 0x00010000 (mask bit 16 set) and high word 0;
  - `msg_valid` is low.
- R2: Register port behaviour:
  - A write to byte offset 0x00 stores `reg_wdata[7:0]` as the index. A read of offset 0x00 returns the index, zero-extended.
  - An access at offset 0x10 acts on the register selected by the index.
  - `reg_rdata` takes its new value on the clock edge that samples `reg_rd`, and holds it until the next read.
  - Any other offset reads 0 and ignores writes.
- R3: Index 1 selects the version register. It always reads 0x00170011, and writes to it change nothing.
- R4: Index 0 (identification) and index 2 (arbitration) accept and return full 32-bit values.
- R5: Table indexing:
  - Index 0x10+2n selects the low word of entry n, and index 0x11+2n selects its high word.
  - Indices 3 to 0x0F, and indices from 0x40 upward, read 0 and drop writes.
- R6: Writes to a low word leave bits 12 and 14 unchanged. These bits are 0, because nothing in this block sets them. So writing 0xFFFFFFFF reads back as 0xFFFFAFFF. High words take the full written value.
- R7: Message field mapping:
  - `msg_vector` comes from low bits 7:0, `msg_dmode` from bits 10:8, `msg_dstmode` from bit 11 and `msg_trig` from bit 15.
  - `msg_dest` comes from high bits 31:24.
  - `msg_shorthand` is 2'b00 (none).
  - `msg_src` is the identification register.
- R8: A raise event on an unmasked pin yields exactly one message. With the output idle, `msg_valid` rises after the second clock edge following the event cycle.
- R9: Three kinds of event produce no message: a raise on a masked pin, a raise with a pin number of 24 or more, and any lower event.
- R10: While `msg_valid` is high and `msg_ready` is low, `msg_valid` and all message fields hold.
- R11: Raises that arrive during a stall are held per pin and sent in ascending pin order once the output is ready. A second raise of a pin that is still pending adds no further message.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte offset (0x00 index, 0x10 data window) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_evt | input | 1 | Pin event strobe |
| irq_raise | input | 1 | 1 = pin raised, 0 = pin lowered |
| irq_num | input | 5 | Pin number of the event |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Receiver accepts message |
| msg_vector | output | 8 | Interrupt vector |
| msg_dmode | output | 3 | Delivery mode |
| msg_dstmode | output | 1 | Destination mode (0 physical, 1 logical) |
| msg_trig | output | 1 | Trigger mode |
| msg_dest | output | 8 | Destination |
| msg_shorthand | output | 2 | Destination shorthand, always none |
| msg_src | output | 32 | Source identification |

## Verification
There are two kinds of internal state, and each fault shows at a port on a known cycle.

A fault in the index or in a table word shows on `reg_rdata` one cycle after the window read. A wrong mask bit or a lost status bit appears there as a single differing bit.

A fault in the pending bits shows on the message output:
- a pending bit that sticks yields an extra message two cycles after it was set;
- a pending bit that drops loses a message in the stalled drain;
- a wrong priority pick reorders the drained messages.

A faulty output register breaks the stable-while-stalled rule on the very next edge.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam logic [31:0] LO_KEEP = 32'h0000_5000;

  typedef struct packed {
    logic [7:0] vector;
    logic [2:0] dmode;
    logic       dstmode;
    logic       trig;
    logic [7:0] dest;
  } ent_view_t;

  typedef struct packed {
    ent_view_t   ent;
    logic [31:0] src;
  } irq_msg_t;

endpackage

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_router_pkg::*;
#(
  parameter int          N        = 24,
  parameter int          ADDR_W   = 8,
  parameter int          IDX_W    = 8,
  parameter logic [31:0] ID_RESET = 32'h0200_0000,
  localparam int         PW       = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [N-1:0]      mask_vec,
  input  logic [PW-1:0]     sel_pin,
  output ent_view_t         sel_ent,
  output logic [31:0]       id_val,
  output logic [IDX_W-1:0]  cur_index
);

  localparam logic [ADDR_W-1:0] A_IDX   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_WIN   = ADDR_W'(16);
  localparam logic [IDX_W-1:0]  I_ID    = IDX_W'(0);
  localparam logic [IDX_W-1:0]  I_VER   = IDX_W'(1);
  localparam logic [IDX_W-1:0]  I_ARB   = IDX_W'(2);
  localparam logic [IDX_W-1:0]  I_BASE  = IDX_W'(16);
  localparam logic [IDX_W-1:0]  I_SPAN  = IDX_W'(2 * N);
  localparam logic [31:0]       VER_VAL = {8'h00, 8'(N - 1), 16'h0011};

  logic [IDX_W-1:0] idx_q;
  logic [31:0]      id_q, arb_q;
  logic [31:0]      lo_mem [N];
  logic [31:0]      hi_mem [N];

  logic [IDX_W-1:0] offs;
  logic             is_tbl;
  logic [PW-1:0]    ent;
  logic [31:0]      win_val;

  assign offs   = idx_q - I_BASE;
  assign is_tbl = (idx_q >= I_BASE) && (offs < I_SPAN);
  assign ent    = PW'(offs >> 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      id_q  <= ID_RESET;
      arb_q <= '0;
      for (int i = 0; i < N; i++) begin
        lo_mem[i] <= (i == 0) ? 32'h0000_0700 : 32'h0001_0000;
        hi_mem[i] <= '0;
      end
    end else if (reg_wr) begin
      if (reg_addr == A_IDX) begin
        idx_q <= reg_wdata[IDX_W-1:0];
      end else if (reg_addr == A_WIN) begin
        if (idx_q == I_ID) begin
          id_q <= reg_wdata;
        end else if (idx_q == I_ARB) begin
          arb_q <= reg_wdata;
        end else if (is_tbl) begin
          if (offs[0]) hi_mem[ent] <= reg_wdata;
          else lo_mem[ent] <= (lo_mem[ent] & LO_KEEP) | (reg_wdata & ~LO_KEEP);
        end
      end
    end
  end

  always_comb begin
    win_val = '0;
    if (idx_q == I_ID) win_val = id_q;
    else if (idx_q == I_VER) win_val = VER_VAL;
    else if (idx_q == I_ARB) win_val = arb_q;
    else if (is_tbl) win_val = offs[0] ? hi_mem[ent] : lo_mem[ent];
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) begin
      if (reg_addr == A_IDX) reg_rdata <= 32'(idx_q);
      else if (reg_addr == A_WIN) reg_rdata <= win_val;
      else reg_rdata <= '0;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_mask
    assign mask_vec[g] = lo_mem[g][16];
  end

  assign sel_ent.vector  = lo_mem[sel_pin][7:0];
  assign sel_ent.dmode   = lo_mem[sel_pin][10:8];
  assign sel_ent.dstmode = lo_mem[sel_pin][11];
  assign sel_ent.trig    = lo_mem[sel_pin][15];
  assign sel_ent.dest    = hi_mem[sel_pin][31:24];
  assign id_val          = id_q;
  assign cur_index       = idx_q;

endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int  N     = 24,
  parameter int  NUM_W = 5,
  localparam int PW    = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             irq_evt,
  input  logic             irq_raise,
  input  logic [NUM_W-1:0] irq_num,
  input  logic [N-1:0]     mask_vec,
  input  logic             take,
  output logic [N-1:0]     pend_q,
  output logic             any,
  output logic [PW-1:0]    pick
);

  logic [N-1:0] set_v, clr_v;

  for (genvar g = 0; g < N; g++) begin : g_set
    assign set_v[g] = irq_evt && irq_raise && (irq_num == NUM_W'(g)) && !mask_vec[g];
    assign clr_v[g] = take && (pick == PW'(g));
  end

  always_comb begin
    pick = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_q[i]) pick = PW'(i);
    end
  end

  assign any = |pend_q;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else pend_q <= (pend_q & ~clr_v) | set_v;
  end

endmodule

// File: rtl/irq_msg_out.sv
module irq_msg_out
  import irq_router_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        any,
  input  ent_view_t   sel_ent,
  input  logic [31:0] src,
  input  logic        msg_ready,
  output logic        take,
  output logic        msg_valid,
  output irq_msg_t    msg_q
);

  assign take = any && (!msg_valid || msg_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid <= 1'b0;
      msg_q     <= '0;
    end else if (take) begin
      msg_valid <= 1'b1;
      msg_q     <= '{ent: sel_ent, src: src};
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int          NUM_PINS = 24,
  parameter int          ADDR_W   = 8,
  parameter int          NUM_W    = 5,
  parameter logic [31:0] ID_RESET = 32'h0200_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              irq_evt,
  input  logic              irq_raise,
  input  logic [NUM_W-1:0]  irq_num,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [7:0]        msg_vector,
  output logic [2:0]        msg_dmode,
  output logic              msg_dstmode,
  output logic              msg_trig,
  output logic [7:0]        msg_dest,
  output logic [1:0]        msg_shorthand,
  output logic [31:0]       msg_src
);

  localparam int PW    = $clog2(NUM_PINS);
  localparam int IDX_W = 8;

  logic [NUM_PINS-1:0] mask_vec, pend_q;
  logic [PW-1:0]       pick;
  logic                any, take;
  ent_view_t           sel_ent;
  logic [31:0]         id_val;
  logic [IDX_W-1:0]    cur_index;
  irq_msg_t            msg_q;

  irq_regfile #(.N(NUM_PINS), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .ID_RESET(ID_RESET)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mask_vec(mask_vec),
    .sel_pin(pick), .sel_ent(sel_ent), .id_val(id_val), .cur_index(cur_index)
  );

  irq_pending #(.N(NUM_PINS), .NUM_W(NUM_W)) u_pend (
    .clk(clk), .rst(rst), .irq_evt(irq_evt), .irq_raise(irq_raise), .irq_num(irq_num),
    .mask_vec(mask_vec), .take(take), .pend_q(pend_q), .any(any), .pick(pick)
  );

  irq_msg_out u_out (
    .clk(clk), .rst(rst), .any(any), .sel_ent(sel_ent), .src(id_val),
    .msg_ready(msg_ready), .take(take), .msg_valid(msg_valid), .msg_q(msg_q)
  );

  assign msg_vector    = msg_q.ent.vector;
  assign msg_dmode     = msg_q.ent.dmode;
  assign msg_dstmode   = msg_q.ent.dstmode;
  assign msg_trig      = msg_q.ent.trig;
  assign msg_dest      = msg_q.ent.dest;
  assign msg_src       = msg_q.src;
  assign msg_shorthand = 2'b00;

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int  N      = 24,
  parameter int  ADDR_W = 8,
  parameter int  NUM_W  = 5,
  localparam int W      = 1 << NUM_W
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_rdata,
  input logic              irq_evt,
  input logic              irq_raise,
  input logic [NUM_W-1:0]  irq_num,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [7:0]        msg_vector,
  input logic [7:0]        msg_dest,
  input logic [31:0]       msg_src,
  input logic [N-1:0]      pend_q,
  input logic [N-1:0]      mask_vec,
  input logic [7:0]        cur_index
);

  localparam logic [31:0] VER_VAL = {8'h00, 8'(N - 1), 16'h0011};

  logic [W-1:0] mask_pad;
  assign mask_pad = {{(W - N){1'b1}}, mask_vec};

  AST_VER_READ: assert property (@(posedge clk) disable iff (rst)
    reg_rd && reg_addr == ADDR_W'(16) && cur_index == 8'd1 |=> reg_rdata == VER_VAL); // R3

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata)); // R2

  AST_NO_PEND_IGNORED: assert property (@(posedge clk) disable iff (rst)
    irq_evt && (!irq_raise || mask_pad[irq_num]) |=> (pend_q & ~$past(pend_q)) == '0); // R9

  AST_PEND_DRAINS: assert property (@(posedge clk) disable iff (rst)
    (pend_q != '0) && !msg_valid |=> msg_valid); // R8

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector) && $stable(msg_dest) && $stable(msg_src)); // R10

  AST_ONE_TAKE: assert property (@(posedge clk) disable iff (rst)
    $countones($past(pend_q) & ~pend_q) <= 1); // R11

endmodule

bind irq_router irq_router_chk #(.N(NUM_PINS), .ADDR_W(ADDR_W), .NUM_W(NUM_W)) u_chk (
  .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .irq_evt(irq_evt), .irq_raise(irq_raise), .irq_num(irq_num), .msg_valid(msg_valid),
  .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_dest(msg_dest), .msg_src(msg_src),
  .pend_q(pend_q), .mask_vec(mask_vec), .cur_index(cur_index)
);

// File: tb/sim_irq_router.sv
`timescale 1ns/1ps
module sim_irq_router;
  localparam int          N   = 24;
  localparam logic [31:0] IDR = 32'h0200_0000;

  logic clk = 0, rst = 1;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq_evt = 0, irq_raise = 0;
  logic [4:0] irq_num = 0;
  logic msg_valid, msg_ready = 1;
  logic [7:0] msg_vector, msg_dest;
  logic [2:0] msg_dmode;
  logic msg_dstmode, msg_trig;
  logic [1:0] msg_shorthand;
  logic [31:0] msg_src;

  irq_router #(.ID_RESET(IDR)) u0 (.*);

  always #5 clk = ~clk;

  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [31:0] m_lo [N];
  logic [31:0] m_hi [N];
  logic [31:0] m_id, m_arb;
  logic [54:0] got [$];
  logic [54:0] expq [$];

  function automatic logic [54:0] cur_msg();
    return {msg_vector, msg_dmode, msg_dstmode, msg_trig, msg_dest, msg_shorthand, msg_src};
  endfunction

  function automatic logic [54:0] exp_msg(int n);
    return {m_lo[n][7:0], m_lo[n][10:8], m_lo[n][11], m_lo[n][15], m_hi[n][31:24], 2'b00, m_id};
  endfunction

  function automatic logic [31:0] model_rd(logic [7:0] idx);
    int o;
    o = int'(idx) - 16;
    if (idx == 0) return m_id;
    if (idx == 1) return 32'h0017_0011;
    if (idx == 2) return m_arb;
    if (o >= 0 && o < 2 * N) return o[0] ? m_hi[o >> 1] : m_lo[o >> 1];
    return 32'h0;
  endfunction

  task automatic model_wr(logic [7:0] idx, logic [31:0] d);
    int o;
    o = int'(idx) - 16;
    if (idx == 0) m_id = d;
    else if (idx == 2) m_arb = d;
    else if (o >= 0 && o < 2 * N) begin
      if (o[0]) m_hi[o >> 1] = d;
      else m_lo[o >> 1] = (m_lo[o >> 1] & 32'h5000) | (d & ~32'h5000);
    end
  endtask

  always @(negedge clk) if (!rst && msg_valid && msg_ready) got.push_back(cur_msg());

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1; tick(); reg_wr = 0;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1; tick(); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic sw_wr(logic [7:0] idx, logic [31:0] d);
    bus_wr(8'h00, {24'h0, idx}); bus_wr(8'h10, d); model_wr(idx, d);
  endtask

  task automatic sw_chk(logic [7:0] idx, string tag);
    logic [31:0] v;
    bus_wr(8'h00, {24'h0, idx}); bus_rd(8'h10, v);
    chk(v == model_rd(idx), tag, v, model_rd(idx));
  endtask

  task automatic raise(int n, bit up);
    irq_num = 5'(n); irq_raise = up; irq_evt = 1; tick(); irq_evt = 0;
  endtask

  task automatic drain(string tag);
    repeat (6) tick();
    chk(got.size() == expq.size(), tag, got.size(), expq.size());
    if (got.size() == expq.size())
      foreach (got[i]) chk(got[i] == expq[i], tag, got[i], expq[i]);
    got.delete(); expq.delete();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, hold;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < N; i++) begin m_lo[i] = (i == 0) ? 32'h700 : 32'h10000; m_hi[i] = 0; end
    m_id = IDR; m_arb = 0;
    repeat (4) tick();
    rst = 0;
    chk(msg_valid == 0, "R1 valid after reset", msg_valid, 0);
    bus_rd(8'h00, v); chk(v == 0, "R1 index reset", v, 0);
    sw_chk(8'h00, "R1 id reset");
    sw_chk(8'h02, "R1 arb reset");
    sw_chk(8'h10, "R1 entry0 lo");
    sw_chk(8'h11, "R1 entry0 hi");
    sw_chk(8'h3E, "R1 entry23 lo");
    sw_chk(8'h1B, "R1 entry5 hi");
    sw_wr(8'h01, 32'hFFFF_FFFF);
    sw_chk(8'h01, "R3 version read-only");
    sw_wr(8'h00, 32'h0300_00A5); sw_chk(8'h00, "R4 id write");
    sw_wr(8'h02, 32'hF0E1_D2C3); sw_chk(8'h02, "R4 arb write");
    bus_wr(8'h00, 32'hABCD_EF37); bus_rd(8'h00, v);
    chk(v == 32'h37, "R2 index readback", v, 32'h37);
    bus_rd(8'h04, v); chk(v == 0, "R2 other offset read", v, 0);
    bus_wr(8'h04, 32'h0000_0011); bus_rd(8'h00, v);
    chk(v == 32'h37, "R2 other offset write ignored", v, 32'h37);
    hold = reg_rdata; repeat (3) tick();
    chk(reg_rdata == hold, "R2 rdata holds", reg_rdata, hold);
    sw_wr(8'h40, 32'hDEAD_BEEF); sw_chk(8'h40, "R5 beyond table");
    sw_chk(8'h05, "R5 gap index");
    sw_wr(8'h3F, 32'h9900_1234); sw_chk(8'h3F, "R5 entry23 hi");
    sw_chk(8'h3E, "R5 entry23 lo untouched");
    sw_wr(8'h16, 32'hFFFF_FFFF); sw_chk(8'h16, "R6 lo keeps status bits");
    sw_wr(8'h16, 32'h0001_0000);
    sw_wr(8'h17, 32'hFFFF_FFFF); sw_chk(8'h17, "R6 hi full write");

    msg_ready = 1;
    sw_wr(8'h18, 32'h0000_8844); sw_wr(8'h19, 32'h5A00_0000);
    raise(4, 1);
    chk(msg_valid == 0, "R8 not valid after one edge", msg_valid, 0);
    tick();
    chk(msg_valid == 1, "R8 valid after two edges", msg_valid, 1);
    chk(cur_msg() == exp_msg(4), "R7 field mapping", cur_msg(), exp_msg(4));
    tick();
    chk(msg_valid == 0, "R8 single message", msg_valid, 0);
    expq.push_back(exp_msg(4)); drain("R8 one message");
    raise(0, 1); expq.push_back(exp_msg(0)); drain("R7 entry0 external mode");

    raise(6, 1); raise(24, 1); raise(31, 1); raise(4, 0);
    drain("R9 ignored events");
    chk(msg_valid == 0, "R9 no valid", msg_valid, 0);

    sw_wr(8'h1E, 32'h0000_0077); sw_wr(8'h1A, 32'h0000_0055);
    sw_wr(8'h14, 32'h0000_0822); sw_wr(8'h22, 32'h0000_0199);
    msg_ready = 0;
    raise(7, 1); repeat (3) tick();
    chk(msg_valid == 1 && msg_vector == 8'h77, "R10 stalled message", msg_vector, 8'h77);
    raise(5, 1); raise(2, 1); raise(9, 1); raise(5, 1);
    repeat (3) tick();
    chk(msg_valid == 1 && msg_vector == 8'h77, "R10 holds while stalled", msg_vector, 8'h77);
    chk(got.size() == 0, "R10 nothing sent while stalled", got.size(), 0);
    expq.push_back(exp_msg(7)); expq.push_back(exp_msg(2));
    expq.push_back(exp_msg(5)); expq.push_back(exp_msg(9));
    msg_ready = 1;
    drain("R11 ascending drain with merge");

    for (int it = 0; it < 400; it++) begin
      int op; logic [7:0] idx; logic [31:0] d;
      op = $urandom % 4;
      idx = ($urandom % 8 == 0) ? 8'($urandom) : 8'($urandom % 72);
      d = $urandom;
      if (($urandom % 2) == 1 && idx >= 8'h10 && idx < 8'h40 && !idx[0]) d[16] = 1'b0;
      if (op == 0) sw_wr(idx, d);
      else if (op == 1) sw_chk(idx, "R5 random read");
      else begin
        int n; bit up;
        n = $urandom % 32; up = ($urandom % 4) != 0;
        raise(n, up);
        if (up && n < N && !m_lo[n][16]) expq.push_back(exp_msg(n));
        drain("R8 random raise");
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule